// File: doc/BRIEF.md
# Wrapped-Code Integer Clock Divider

The block divides its input clock by an integer ratio between 4 and 259, chosen by an 8-bit code. Codes 4 to 255 give that ratio directly. The four smallest codes would otherwise be useless as ratios, so they are reused to reach 256 to 259. Internally the ratio is therefore carried as a 9-bit value.

The divided output has a duty cycle as close to 50% as an integer count allows. A single-cycle marker pulse accompanies every rising edge of the divided output.

A new code is captured by a load strobe but only steers the divider at the next period boundary. Every period is completed at the ratio it started with. The asynchronous active-low reset is released through a two-stage synchronizer. After reset the block divides by 4.

Top module: `clkdiv_wrap`

## Requirements
- R1: With a loaded code c in the range 4..255, every output period (pulse to pulse) lasts exactly c input clock cycles.
- R2: Loaded codes 0, 1, 2 and 3 give periods of 256, 257, 258 and 259 input cycles respectively (ratio = code + 256 for codes below 4).
- R3: For a ratio N the divided output is high for (N+1)/2 cycles (integer division) at the start of each period and low for the remaining N/2 cycles.
- R4: The period pulse is high for exactly one input cycle, in the first cycle of each period, which is the cycle in which the divided output goes from low to high.
- R5: A code loaded part-way through a period does not shorten or lengthen that period; it governs the following period.
- R6: When several loads fall within one period, only the last loaded code is used for the next period.
- R7: A load sampled on the rising edge that begins the last output cycle of a period governs the very next period. A load sampled one edge later, in the first cycle of the next period, governs only the period after that.
- R8: While reset is asserted both outputs are low. After rst_ni rises, the first pulse appears in the cycle after the third rising clock edge. The ratio then is 4 until a code is loaded.
- R9: Changes on ratio_code_i without load_i have no effect on the output periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_code_i | input | 8 | Ratio code in bits 7:0; 4..255 direct, 0..3 mean 256..259 |
| load_i | input | 1 | One-cycle strobe capturing ratio_code_i |
| div_clk_o | output | 1 | Divided clock |
| period_pulse_o | output | 1 | One-cycle marker on each rising edge of div_clk_o |

## Verification
The two functions that can fall in the same cycle are the capture of a new code and the wrap of the period counter. At that edge the design must hand the freshly sampled code straight to the next period, while any older pending code is discarded. The bench places a load on the exact edge that begins the last output cycle of a period, and again one edge later. It judges each case by measuring the lengths of the next two periods at the ports. Random loads at random offsets, checked against a cycle model in the bench, also hit this collision many times.

// File: rtl/clkdiv_wrap_pkg.sv
package clkdiv_wrap_pkg;

  // Default widths and ratios shared by the divider modules
  localparam int unsigned CODE_W_DEF      = 8;
  localparam int unsigned WRAP_CODES_DEF  = 4;
  localparam int unsigned RESET_RATIO_DEF = 4;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // Number of high cycles for a period of n cycles (round half up)
  function automatic int unsigned high_cycles(input int unsigned n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/clkdiv_ratio_sel.sv
module clkdiv_ratio_sel #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned WRAP_CODES  = 4,
  parameter int unsigned RESET_RATIO = 4,
  localparam int unsigned RATIO_W    = CODE_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               wrap_i,
  output logic [RATIO_W-1:0] ratio_o
);

  logic [CODE_W-1:0]  pend_q, pend_d;
  logic               pend_vld_q, pend_vld_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               pend_en, ratio_en;
  logic [CODE_W-1:0]  src_code;
  logic               src_wrapped;
  logic [RATIO_W-1:0] src_ratio;

  // A load in the wrap cycle bypasses the pending register
  assign src_code = load_i ? code_i : pend_q;

  generate
    if (WRAP_CODES > 0) begin : g_wrap
      assign src_wrapped = (src_code < CODE_W'(WRAP_CODES));
    end else begin : g_nowrap
      assign src_wrapped = 1'b0;
    end
  endgenerate

  assign src_ratio = {src_wrapped, src_code};

  always_comb begin
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    ratio_d    = ratio_q;
    pend_en    = 1'b0;
    ratio_en   = 1'b0;
    if (wrap_i) begin
      pend_vld_d = 1'b0;
      ratio_en   = load_i | pend_vld_q;
      ratio_d    = src_ratio;
    end else if (load_i) begin
      pend_en    = 1'b1;
      pend_d     = code_i;
      pend_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      ratio_q    <= RATIO_W'(RESET_RATIO);
    end else begin
      pend_vld_q <= pend_vld_d;
      if (pend_en) begin
        pend_q <= pend_d;
      end
      if (ratio_en) begin
        ratio_q <= ratio_d;
      end
    end
  end

  assign ratio_o = ratio_q;

endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt #(
  parameter int unsigned RATIO_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [RATIO_W-1:0] cnt_o,
  output logic               wrap_o
);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               last_cyc;

  assign last_cyc = (cnt_q == (ratio_i - RATIO_W'(1)));

  always_comb begin
    if (last_cyc) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = last_cyc;

endmodule

// File: rtl/clkdiv_out_gen.sv
module clkdiv_out_gen #(
  parameter int unsigned RATIO_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] cnt_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               div_clk_o,
  output logic               pulse_o
);

  logic [RATIO_W:0]   half_sum;
  logic [RATIO_W-1:0] high_len;
  logic               div_q, div_d;
  logic               pulse_q, pulse_d;

  // Round-up half of the ratio: odd ratios get the extra high cycle
  assign half_sum = {1'b0, ratio_i} + (RATIO_W+1)'(1);
  assign high_len = half_sum[RATIO_W:1];

  always_comb begin
    div_d   = (cnt_i < high_len);
    pulse_d = (cnt_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      pulse_q <= pulse_d;
    end
  end

  assign div_clk_o = div_q;
  assign pulse_o   = pulse_q;

endmodule

// File: rtl/clkdiv_wrap.sv
module clkdiv_wrap
  import clkdiv_wrap_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned WRAP_CODES  = WRAP_CODES_DEF,
  parameter int unsigned RESET_RATIO = RESET_RATIO_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic              load_i,
  output logic              div_clk_o,
  output logic              period_pulse_o
);

  localparam int unsigned RATIO_W = CODE_W + 1;

  logic               rst_sync_n;
  logic [RATIO_W-1:0] cur_ratio;
  logic [RATIO_W-1:0] phase_cnt;
  logic               period_wrap;

  clkdiv_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  clkdiv_ratio_sel #(
    .CODE_W      (CODE_W),
    .WRAP_CODES  (WRAP_CODES),
    .RESET_RATIO (RESET_RATIO)
  ) u_ratio_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .load_i  (load_i),
    .code_i  (ratio_code_i),
    .wrap_i  (period_wrap),
    .ratio_o (cur_ratio)
  );

  clkdiv_phase_cnt #(
    .RATIO_W (RATIO_W)
  ) u_phase_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .ratio_i (cur_ratio),
    .cnt_o   (phase_cnt),
    .wrap_o  (period_wrap)
  );

  clkdiv_out_gen #(
    .RATIO_W (RATIO_W)
  ) u_out_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .cnt_i     (phase_cnt),
    .ratio_i   (cur_ratio),
    .div_clk_o (div_clk_o),
    .pulse_o   (period_pulse_o)
  );

endmodule

// File: rtl/clkdiv_wrap_chk.sv
module clkdiv_wrap_chk #(
  parameter int unsigned RATIO_W   = 9,
  parameter int unsigned MIN_RATIO = 4,
  parameter int unsigned MAX_RATIO = 259
) (
  input logic               clk,
  input logic               rst_n,
  input logic               div_clk,
  input logic               pulse,
  input logic [RATIO_W-1:0] ratio,
  input logic [RATIO_W-1:0] cnt
);

  logic [RATIO_W-1:0] hi_run;
  logic [RATIO_W:0]   ratio_up;

  assign ratio_up = {1'b0, ratio} + (RATIO_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
    end else if (!div_clk) begin
      hi_run <= '0;
    end else begin
      hi_run <= hi_run + RATIO_W'(1);
    end
  end

  // R4
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (div_clk && !$past(div_clk)));

  // R4
  rise_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |-> pulse);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R2
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= RATIO_W'(MIN_RATIO)) && (ratio <= RATIO_W'(MAX_RATIO)));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);

  // R5
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(ratio));

  // R3
  high_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_clk) |-> (hi_run == ratio_up[RATIO_W:1]));

endmodule

bind clkdiv_wrap clkdiv_wrap_chk #(
  .RATIO_W (RATIO_W)
) chk_i (
  .clk     (clk_i),
  .rst_n   (rst_sync_n),
  .div_clk (div_clk_o),
  .pulse   (period_pulse_o),
  .ratio   (cur_ratio),
  .cnt     (phase_cnt)
);

// File: tb/clkdiv_wrap_tb_top.sv
`timescale 1ns/1ps
module clkdiv_wrap_tb_top;

  logic       clk;
  logic       rst_n;
  logic       load;
  logic [7:0] code;
  logic       div_clk;
  logic       pulse;

  int    checks;
  int    fails;
  bit    done;
  string cur_req;

  clkdiv_wrap dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ratio_code_i   (code),
    .load_i         (load),
    .div_clk_o      (div_clk),
    .period_pulse_o (pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_ratio(input int c);
    return (c < 4) ? c + 256 : c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle model built from the requirements: position within period and
  // the ratio of the running period; outputs follow one edge later.
  logic [1:0] m_sync;
  int         m_cur, m_pos, m_pend;
  bit         m_pv, m_out, m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync  <= 2'b00;
      m_cur   <= 4;
      m_pos   <= 0;
      m_pend  <= 0;
      m_pv    <= 1'b0;
      m_out   <= 1'b0;
      m_pulse <= 1'b0;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        m_out   <= (m_pos < (m_cur + 1) / 2);
        m_pulse <= (m_pos == 0);
        if (m_pos == m_cur - 1) begin
          m_pos <= 0;
          m_pv  <= 1'b0;
          if (load)      m_cur <= exp_ratio(int'(code));
          else if (m_pv) m_cur <= exp_ratio(m_pend);
        end else begin
          m_pos <= m_pos + 1;
          if (load) begin
            m_pend <= int'(code);
            m_pv   <= 1'b1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    check({cur_req, " div_clk vs model"}, int'(div_clk), int'(m_out));
    check({cur_req, " pulse vs model"}, int'(pulse), int'(m_pulse));
  end

  // Drive a one-cycle load from the current negedge
  task automatic load_now(input int c);
    code = 8'(c);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Measure one full period from the next (or current) pulse
  task automatic measure(input int exp_n, input string req);
    int len;
    int hi;
    while (!pulse) @(negedge clk);
    len = 1;
    hi  = int'(div_clk);
    forever begin
      @(negedge clk);
      if (pulse) break;
      len++;
      hi += int'(div_clk);
    end
    check({req, " period length"}, len, exp_n);
    check("R3 high cycles", hi, (exp_n + 1) / 2);
  endtask

  // Starting at a pulse, measure this period while loading at offset k
  task automatic period_with_load(input int k, input int c, input int exp_n,
                                  input string req);
    int len;
    len = 1;
    forever begin
      if (len - 1 == k) begin
        code = 8'(c);
        load = 1'b1;
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
      if (pulse) break;
      len++;
    end
    load = 1'b0;
    check({req, " current period kept"}, len, exp_n);
  endtask

  task automatic set_and_measure(input int c, input string req);
    load_now(c);
    measure(exp_ratio(c), req);
  endtask

  initial begin
    int cnt;
    checks  = 0;
    fails   = 0;
    done    = 1'b0;
    cur_req = "R8";
    rst_n   = 1'b0;
    load    = 1'b0;
    code    = 8'd4;
    void'($urandom(32'd2024));

    // R8: reset state and release timing
    repeat (3) @(negedge clk);
    check("R8 div_clk in reset", int'(div_clk), 0);
    check("R8 pulse in reset", int'(pulse), 0);
    rst_n = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!pulse && cnt < 20);
    check("R8 edges to first pulse", cnt, 3);
    measure(4, "R8 default ratio");

    // R1: direct codes
    cur_req = "R1";
    set_and_measure(4, "R1");
    set_and_measure(5, "R1");
    set_and_measure(7, "R1");
    set_and_measure(100, "R1");
    set_and_measure(255, "R1");

    // R2: wrapped codes
    cur_req = "R2";
    for (int c = 0; c < 4; c++) set_and_measure(c, "R2");

    // R9: code changes without a load
    cur_req = "R9";
    set_and_measure(9, "R9");
    code = 8'd200;
    measure(9, "R9");
    code = 8'd2;
    measure(9, "R9");

    // R6: two loads in one period, last wins
    cur_req = "R6";
    load_now(20);
    load_now(11);
    measure(11, "R6");
    measure(11, "R6");

    // R5: mid-period load leaves the current period intact
    cur_req = "R5";
    period_with_load(2, 30, 11, "R5");
    measure(30, "R5");

    // R7: load on the wrap edge, then one edge late
    cur_req = "R7";
    period_with_load(28, 12, 30, "R7");
    measure(12, "R7");
    period_with_load(11, 6, 12, "R7");
    measure(12, "R7");
    measure(6, "R7");

    // Random loads at random offsets against the model
    cur_req = "R5 random";
    for (int i = 0; i < 400; i++) begin
      int gap;
      int pick;
      pick = int'($urandom_range(0, 19));
      if (pick == 0) code = 8'($urandom_range(0, 3));
      else           code = 8'($urandom_range(4, 24));
      load = ($urandom_range(0, 2) == 0);
      @(negedge clk);
      load = 1'b0;
      gap = int'($urandom_range(0, 8));
      repeat (gap) @(negedge clk);
    end
    load_now(5);
    measure(5, "R1 after random");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule